// File: doc/BRIEF.md
# Asynchronous Static Memory Access Sequencer

This block turns a single host request into one timed access on an asynchronous external memory (NOR Flash, SRAM or PSRAM). The host presents a request with a read/write flag, a bank number, a 26-bit address and 16-bit write data. The sequencer then walks the memory pins through up to four phases, each with its own length counted in system clock cycles. Address setup comes first. Address hold follows, but only when address and data share the data pins. Data setup comes next, and bus turnaround is last. At the end the host gets a one-cycle done pulse and, for reads, the captured data.

Phase lengths and the I/O mode come from configuration inputs. The block samples them at the moment a request is accepted and uses those values for the whole access. Four active-low chip selects address four banks. The active-low output enable, write enable and address-valid strobes frame the data and address phases. The data pins are split into an output value, an output enable and an input value, so that the tri-state buffer can be placed at the pad.

Top module: `smc_async_seq`

## Requirements
- R1: The address-setup phase lasts `cfg_aset` cycles (0 to 15), and 0 skips it; `mem_adv_n` is low exactly during this phase.
- R2: In multiplexed mode (`cfg_muxed`=1), an address-hold phase of `cfg_ahld` cycles follows address setup, with a field value of 0 treated as 1. During this phase chip select is low and `mem_adv_n`, `mem_oe_n` and `mem_we_n` are high. In non-multiplexed mode the phase is absent.
- R3: The data-setup phase lasts `cfg_dset`+1 cycles (1 to 256). `mem_oe_n` is low for exactly that phase on a read (`wr`=0), and `mem_we_n` is low for exactly that phase on a write (`wr`=1). The two are never low together.
- R4: `mem_dq_oe` is high with `mem_dq_out` equal to the write data for the whole data phase of a write. In multiplexed mode it is also high with `mem_dq_out` equal to address bits [15:0] during setup and hold. It is never high while `mem_oe_n` is low.
- R5: A read captures `mem_dq_in` on the final data-setup cycle, and `rdata` holds that value from the done pulse on.
- R6: A turnaround phase of `cfg_turn` cycles (0 to 15) follows data setup, with all chip selects high. `done` is a one-cycle pulse seen A+H+D+T cycles after the accepting clock edge, where the four terms are the phase lengths of R1, R2, R3 and R6.
- R7: Only `mem_cs_n[bank]` goes low, and it stays low continuously from the start of address setup to the end of data setup. The other selects stay high.
- R8: A request is accepted only when no access is in progress. A request raised and dropped during an access is ignored: it causes no second access and does not alter the address.
- R9: Configuration changes made during an access do not alter that access's phase lengths or mode.
- R10: After reset all chip selects, `mem_oe_n`, `mem_we_n` and `mem_adv_n` are high, and `mem_dq_oe` and `done` are low.
- R11: `mem_addr` carries all 26 bits of the accepted address while chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_aset | input | 4 | Address-setup length in cycles |
| cfg_ahld | input | 4 | Address-hold length in cycles (multiplexed mode) |
| cfg_dset | input | 8 | Data-setup length minus one |
| cfg_turn | input | 4 | Turnaround length in cycles |
| cfg_muxed | input | 1 | 1: address and data share the data pins |
| req | input | 1 | Access request, taken when idle |
| wr | input | 1 | 1 write, 0 read |
| bank | input | 2 | Chip-select bank |
| addr | input | 26 | Access address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Captured read data |
| done | output | 1 | One-cycle end-of-access pulse |
| mem_addr | output | 26 | Memory address bus |
| mem_dq_out | output | 16 | Value driven onto the data pins |
| mem_dq_oe | output | 1 | Data pin output enable |
| mem_dq_in | input | 16 | Value read from the data pins |
| mem_cs_n | output | 4 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_adv_n | output | 1 | Active-low address valid / latch enable |

## Verification
The accepting clock edge is counted as edge 0. Every memory-side level belonging to phase k is then visible between edges k-1 and k. `done` and `rdata` are first visible after edge A+H+D+T. The bench raises the request half a cycle before an edge and samples every pin on the falling edge of each following cycle. It tallies the cycles spent in each strobe state until `done` appears and compares each tally with the phase lengths that its own functions derive from the configuration. One more falling-edge sample after `done` confirms that the pulse has ended and that the bus has gone quiet.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
  parameter int unsigned SET_W = 4;             // setup / hold / turnaround fields
  parameter int unsigned DST_W = 8;             // data-setup field
  localparam int unsigned CNT_W = DST_W + 1;    // holds up to 2**DST_W

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASET, PH_AHLD, PH_DSET, PH_TURN
  } phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] aset;
    logic [CNT_W-1:0] ahld;
    logic [CNT_W-1:0] dset;
    logic [CNT_W-1:0] turn;
  } len_t;

  // Field values to phase lengths in cycles.
  function automatic len_t lens_from_cfg(input logic [SET_W-1:0] aset_f,
                                         input logic [SET_W-1:0] ahld_f,
                                         input logic [DST_W-1:0] dset_f,
                                         input logic [SET_W-1:0] turn_f,
                                         input logic             muxed);
    len_t l;
    l.aset = CNT_W'(aset_f);
    if (!muxed)
      l.ahld = '0;
    else if (ahld_f == '0)
      l.ahld = CNT_W'(1);
    else
      l.ahld = CNT_W'(ahld_f);
    l.dset = CNT_W'(dset_f) + CNT_W'(1);
    l.turn = CNT_W'(turn_f);
    return l;
  endfunction

  function automatic logic [CNT_W-1:0] phase_len(input phase_e p, input len_t l);
    case (p)
      PH_ASET: return l.aset;
      PH_AHLD: return l.ahld;
      PH_DSET: return l.dset;
      PH_TURN: return l.turn;
      default: return CNT_W'(1);
    endcase
  endfunction

  // Next phase with a non-zero length; from idle this is the first phase.
  function automatic phase_e phase_after(input phase_e p, input len_t l);
    case (p)
      PH_IDLE: begin
        if (l.aset != '0)      return PH_ASET;
        else if (l.ahld != '0) return PH_AHLD;
        else                   return PH_DSET;
      end
      PH_ASET: return (l.ahld != '0) ? PH_AHLD : PH_DSET;
      PH_AHLD: return PH_DSET;
      PH_DSET: return (l.turn != '0) ? PH_TURN : PH_IDLE;
      default: return PH_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/smc_phase_seq.sv
`timescale 1ns/1ps
module smc_phase_seq
  import smc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_i,
  input  len_t   lens_i,
  output phase_e phase_o,
  output logic   last_o,
  output logic   busy_o,
  output logic   done_o
);
  phase_e           phase_q, nxt;
  logic [CNT_W-1:0] cnt_q;
  len_t             lens_q, lens_use;
  logic             done_q, go;

  always_comb begin
    lens_use = (phase_q == PH_IDLE) ? lens_i : lens_q;
    nxt      = phase_after(phase_q, lens_use);
    go       = (phase_q == PH_IDLE) ? start_i : (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      lens_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (phase_q == PH_IDLE && start_i)
        lens_q <= lens_i;
      if (go) begin
        phase_q <= nxt;
        cnt_q   <= phase_len(nxt, lens_use) - CNT_W'(1);
        done_q  <= (phase_q != PH_IDLE) && (nxt == PH_IDLE);
      end else if (phase_q != PH_IDLE) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign phase_o = phase_q;
  assign busy_o  = (phase_q != PH_IDLE);
  assign last_o  = (phase_q != PH_IDLE) && (cnt_q == '0);
  assign done_o  = done_q;
endmodule

// File: rtl/smc_bank_dec.sv
`timescale 1ns/1ps
module smc_bank_dec #(
  parameter int unsigned BANKS = 4,
  localparam int unsigned SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [BANKS-1:0] cs_n_o
);
  for (genvar g = 0; g < BANKS; g++) begin : g_cs
    assign cs_n_o[g] = !(en_i && (sel_i == SEL_W'(g)));
  end
endmodule

// File: rtl/smc_io_path.sv
`timescale 1ns/1ps
module smc_io_path
  import smc_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              muxed_i,
  input  phase_e            phase_i,
  input  logic              last_i,
  input  logic [DATA_W-1:0] dq_in_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] dq_out_o,
  output logic              dq_oe_o,
  output logic              oe_n_o,
  output logic              we_n_o,
  output logic              adv_n_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              we_q, muxed_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [BANK_W-1:0] bank_q;

  // Named phase events.
  logic addr_phase, data_phase, rd_capture;
  assign addr_phase = (phase_i == PH_ASET) || (phase_i == PH_AHLD);
  assign data_phase = (phase_i == PH_DSET);
  assign rd_capture = data_phase && last_i && !we_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      muxed_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      bank_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (start_i) begin
        we_q    <= we_i;
        muxed_q <= muxed_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        bank_q  <= bank_i;
      end
      if (rd_capture)
        rdata_q <= dq_in_i;
    end
  end

  assign mem_addr_o = addr_q;
  assign adv_n_o    = !(phase_i == PH_ASET);
  assign oe_n_o     = !(data_phase && !we_q);
  assign we_n_o     = !(data_phase && we_q);
  assign dq_oe_o    = (addr_phase && muxed_q) || (data_phase && we_q);
  assign dq_out_o   = addr_phase ? addr_q[DATA_W-1:0] : wdata_q;
  assign bank_o     = bank_q;
  assign rdata_o    = rdata_q;
endmodule

// File: rtl/smc_async_seq.sv
`timescale 1ns/1ps
module smc_async_seq
  import smc_pkg::*;
#(
  parameter int unsigned ADDR_W = 26,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BANKS  = 4,
  localparam int unsigned BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  cfg_aset,
  input  logic [SET_W-1:0]  cfg_ahld,
  input  logic [DST_W-1:0]  cfg_dset,
  input  logic [SET_W-1:0]  cfg_turn,
  input  logic              cfg_muxed,
  input  logic              req,
  input  logic              wr,
  input  logic [BANK_W-1:0] bank,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [BANKS-1:0]  mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n
);
  // Named internal events for the checker.
  phase_e            seq_phase;
  logic              seq_last, seq_busy, accept, cs_en;
  len_t              cfg_lens;
  logic [BANK_W-1:0] bank_q;

  assign cfg_lens = lens_from_cfg(cfg_aset, cfg_ahld, cfg_dset, cfg_turn, cfg_muxed);
  assign accept   = req && !seq_busy;
  assign cs_en    = (seq_phase == PH_ASET) || (seq_phase == PH_AHLD) ||
                    (seq_phase == PH_DSET);

  smc_phase_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (accept),
    .lens_i  (cfg_lens),
    .phase_o (seq_phase),
    .last_o  (seq_last),
    .busy_o  (seq_busy),
    .done_o  (done)
  );

  smc_io_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_io (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (accept),
    .we_i       (wr),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .bank_i     (bank),
    .muxed_i    (cfg_muxed),
    .phase_i    (seq_phase),
    .last_i     (seq_last),
    .dq_in_i    (mem_dq_in),
    .mem_addr_o (mem_addr),
    .dq_out_o   (mem_dq_out),
    .dq_oe_o    (mem_dq_oe),
    .oe_n_o     (mem_oe_n),
    .we_n_o     (mem_we_n),
    .adv_n_o    (mem_adv_n),
    .bank_o     (bank_q),
    .rdata_o    (rdata)
  );

  smc_bank_dec #(.BANKS(BANKS)) u_cs (
    .en_i   (cs_en),
    .sel_i  (bank_q),
    .cs_n_o (mem_cs_n)
  );
endmodule

// File: rtl/smc_async_seq_chk.sv
`timescale 1ns/1ps
module smc_async_seq_chk #(
  parameter int unsigned BANKS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             last,
  input logic             done,
  input logic [BANKS-1:0] cs_n,
  input logic             oe_n,
  input logic             we_n,
  input logic             adv_n,
  input logic             dq_oe
);
  p_cs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  p_strobe_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n || !we_n || !adv_n) |-> (cs_n != {BANKS{1'b1}}));

  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n == {BANKS{1'b1}}) && oe_n && we_n && !dq_oe);

  p_busy_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

bind smc_async_seq smc_async_seq_chk #(.BANKS(BANKS)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .busy  (seq_busy),
  .last  (seq_last),
  .done  (done),
  .cs_n  (mem_cs_n),
  .oe_n  (mem_oe_n),
  .we_n  (mem_we_n),
  .adv_n (mem_adv_n),
  .dq_oe (mem_dq_oe)
);

// File: tb/tb_smc_async_seq.sv
`timescale 1ns/1ps
module tb_smc_async_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  cfg_aset, cfg_ahld, cfg_turn;
  logic [7:0]  cfg_dset;
  logic        cfg_muxed, req, wr;
  logic [1:0]  bank;
  logic [25:0] addr, mem_addr;
  logic [15:0] wdata, rdata, mem_dq_out, mem_dq_in;
  logic        done, mem_dq_oe, mem_oe_n, mem_we_n, mem_adv_n;
  logic [3:0]  mem_cs_n;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  smc_async_seq dut (.*);

  // Memory model: value depends on the presented address, only while read enabled.
  function automatic logic [15:0] rdpat(input logic [25:0] a);
    return a[15:0] ^ {a[25:16], 6'h2A};
  endfunction
  assign mem_dq_in = mem_oe_n ? 16'hF00F : rdpat(mem_addr);

  function automatic int exp_hold(input logic mx, input int f);
    if (!mx) return 0;
    return (f < 1) ? 1 : f;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic run_access(input logic w, input logic [1:0] bk, input logic [25:0] ad,
                            input logic [15:0] wd, input int a, input int h,
                            input int d, input int t, input logic mx,
                            input bit disturb);
    int eH, eD, S, i;
    int cs_cnt, adv_cnt, hold_cnt, oe_cnt, we_cnt, dq_cnt, bad_cs, bad_addr, bad_dq;
    eH = exp_hold(mx, h);
    eD = d + 1;
    S  = a + eH + eD + t;
    cs_cnt = 0; adv_cnt = 0; hold_cnt = 0; oe_cnt = 0; we_cnt = 0;
    dq_cnt = 0; bad_cs = 0; bad_addr = 0; bad_dq = 0;
    @(negedge clk);
    cfg_aset = 4'(a); cfg_ahld = 4'(h); cfg_dset = 8'(d); cfg_turn = 4'(t);
    cfg_muxed = mx; wr = w; bank = bk; addr = ad; wdata = wd; req = 1'b1;
    i = 0;
    while (1) begin
      @(negedge clk);
      i++;
      if (i == 1) req = 1'b0;
      if (disturb && i == 2) begin   // R8, R9: stray request and new config mid-access
        req = 1'b1; addr = ~ad; wr = ~w; bank = bk + 2'd1;
        cfg_aset = ~4'(a); cfg_ahld = ~4'(h); cfg_dset = ~8'(d);
        cfg_turn = ~4'(t); cfg_muxed = ~mx;
      end
      if (disturb && i == 3) req = 1'b0;
      if (done || i > 700) break;
      if (mem_cs_n != 4'hF) begin
        cs_cnt++;
        if (mem_cs_n != ~(4'b0001 << bk)) bad_cs++;
        if (mem_addr != ad) bad_addr++;
      end
      if (!mem_adv_n) adv_cnt++;
      if (mem_cs_n != 4'hF && mem_adv_n && mem_oe_n && mem_we_n) hold_cnt++;
      if (!mem_oe_n) oe_cnt++;
      if (!mem_we_n) we_cnt++;
      if (mem_dq_oe) begin
        dq_cnt++;
        if (!mem_we_n && mem_dq_out != wd) bad_dq++;
        if (mem_we_n && mem_dq_out != ad[15:0]) bad_dq++;
      end
    end
    chk(i - 1 == S, disturb ? "R6/R9" : "R6", "cycles to done", i - 1, S);
    chk(adv_cnt == a, disturb ? "R1/R9" : "R1", "adv low cycles", adv_cnt, a);
    chk(hold_cnt == eH, "R2", "hold cycles", hold_cnt, eH);
    chk((w ? we_cnt : oe_cnt) == eD, "R3", "strobe cycles", w ? we_cnt : oe_cnt, eD);
    chk((w ? oe_cnt : we_cnt) == 0, "R3", "wrong strobe cycles", w ? oe_cnt : we_cnt, 0);
    chk(dq_cnt == (mx ? a + eH : 0) + (w ? eD : 0), "R4", "dq drive cycles", dq_cnt,
        (mx ? a + eH : 0) + (w ? eD : 0));
    chk(bad_dq == 0, "R4", "dq value errors", bad_dq, 0);
    chk(cs_cnt == a + eH + eD, "R7", "cs low cycles", cs_cnt, a + eH + eD);
    chk(bad_cs == 0, "R7", "wrong cs pattern", bad_cs, 0);
    chk(bad_addr == 0, disturb ? "R11/R8" : "R11", "address errors", bad_addr, 0);
    if (!w) chk(rdata == rdpat(ad), "R5", "read data", rdata, rdpat(ad));
    cfg_aset = 4'(a); cfg_ahld = 4'(h); cfg_dset = 8'(d); cfg_turn = 4'(t); cfg_muxed = mx;
    @(negedge clk);
    chk(!done, "R6", "done width", done, 0);
    chk(mem_cs_n == 4'hF, disturb ? "R8" : "R6", "bus idle after done", mem_cs_n, 15);
    if (!w) chk(rdata == rdpat(ad), "R5", "read data held", rdata, rdpat(ad));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; bank = '0; addr = '0; wdata = '0;
    cfg_aset = '0; cfg_ahld = '0; cfg_dset = '0; cfg_turn = '0; cfg_muxed = 1'b0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(mem_cs_n == 4'hF, "R10", "cs in reset", mem_cs_n, 15);
    chk({mem_oe_n, mem_we_n, mem_adv_n} == 3'b111, "R10", "strobes in reset",
        {mem_oe_n, mem_we_n, mem_adv_n}, 7);
    chk(!mem_dq_oe && !done, "R10", "dq_oe/done in reset", {mem_dq_oe, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // Directed corners
    run_access(1'b0, 2'd0, 26'h0000001, 16'h0000, 0, 0, 0, 0, 1'b0, 1'b0);   // shortest read
    run_access(1'b1, 2'd1, 26'h3FFFFFF, 16'hA5C3, 0, 0, 0, 0, 1'b0, 1'b0);   // shortest write
    run_access(1'b0, 2'd2, 26'h2345678, 16'h0000, 0, 0, 0, 0, 1'b1, 1'b0);   // R2 hold field 0 -> 1
    run_access(1'b1, 2'd3, 26'h1ABCDEF, 16'h5A5A, 15, 15, 255, 15, 1'b1, 1'b0); // longest
    run_access(1'b0, 2'd3, 26'h0F0F0F0, 16'h0000, 15, 9, 255, 15, 1'b0, 1'b0);
    run_access(1'b1, 2'd0, 26'h2000000, 16'hFFFF, 3, 4, 5, 6, 1'b1, 1'b1);   // R8, R9
    run_access(1'b0, 2'd1, 26'h1555555, 16'h0000, 2, 1, 7, 3, 1'b0, 1'b1);   // R8, R9
    // Random accesses
    for (int k = 0; k < 60; k++) begin
      run_access(1'($urandom), 2'($urandom), 26'($urandom), 16'($urandom),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                 int'($urandom_range(0, 40)), int'($urandom_range(0, 15)),
                 1'($urandom), (k % 7) == 3);
    end
    summary();
    $finish;
  end
endmodule